// File: doc/BRIEF.md
# Half-Band Rate-Change Sequencer

This block is the timing controller that sits around a fixed half-band low-pass filter core. On every clock it tells the datapath three things:

- whether the filter delay line moves;
- whether the sample entering it is the word on the input port or a stuffed zero;
- whether the output register captures a new result.

It also hands the output stage a code that selects the gain and the overflow limits. Two mode pins choose the operating mode, and a parameter chooses between two variants. The modes are equal-rate, 2:1 decimation, and 1:2 interpolation at half gain. The second variant adds 1:2 interpolation at unity gain.

In the two rate-changing modes, a free-running half-rate phase decides which clocks accept data (interpolation) or load the output register (decimation). A sync input re-aligns that phase. Holding sync high for a clock and then low marks the low clock as an accept/load clock. Sync may be left low after that, or toggled every clock, and the result is the same. In equal-rate mode sync does nothing. The arithmetic, rounding and limiting are done elsewhere. This block only chooses the limit code.

Top module: `hb_rate_seq`

## Requirements
- R1: With VARIANT=0 the pins {dec_i,int_i} decode as follows: 2'b01 is decimation, 2'b10 is half-gain interpolation, and 2'b00 and 2'b11 are both equal-rate.
- R2: With VARIANT=1 the decode matches R1, except that {dec_i,int_i}=2'b00 selects unity-gain interpolation.
- R3: In equal-rate mode, adv_o, take_o and oload_o are 1 and zero_o is 0 on every active clock, whatever sync_i does.
- R4: In either interpolation mode, adv_o and oload_o are 1 on every active clock. take_o and zero_o are complementary and alternate from clock to clock, so a stuffed zero follows every accepted word.
- R5: In decimation mode, adv_o, take_o and zero_o=0 hold on every active clock, and oload_o is 1 on alternate clocks only.
- R6: Outside equal-rate mode, a clock with sync_i low whose previous clock had sync_i high is an accept clock (take_o=1 while interpolating, oload_o=1 while decimating), and the half-rate phase continues from there.
- R7: After alignment, toggling sync_i every clock gives exactly the same strobes as holding it low.
- R8: gain_o is 0 (unity gain, 16-bit limits) in equal-rate, decimation and unity-gain interpolation. In half-gain interpolation it is 1 (half gain, 16-bit limits) with VARIANT=0 and 2 (half gain, 15-bit limits) with VARIANT=1. The value 3 never occurs.
- R9: While rst_n is low, and on the first clock after it rises, adv_o, take_o, zero_o and oload_o are 0 and gain_o is 0. The phase then starts on an accept clock.
- R10: New mode pins take effect on the clock after they are sampled. The first clock in the new mode is an accept clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_i | input | 1 | Mode pin, decimate select (see R1/R2) |
| int_i | input | 1 | Mode pin, interpolate select (see R1/R2) |
| sync_i | input | 1 | Half-rate phase alignment |
| adv_o | output | 1 | Filter delay line advances this clock |
| take_o | output | 1 | Input word is taken into the filter this clock |
| zero_o | output | 1 | A zero sample is fed to the filter instead of the input |
| oload_o | output | 1 | Output register loads this clock |
| gain_o | output | 2 | Gain/limit code for the output stage (see R8) |

## Verification
The bench drives both variants side by side and compares every strobe on every clock against a behavioural model, so a wrong decode of pin pattern 00 appears at once as a gain_o or take_o mismatch on one instance.

It places sync pulses on clocks that disagree with the free-running phase. A design that ignored sync, or aligned one clock late, would take or load on the wrong parity.

It toggles sync in equal-rate mode, where a design that honoured sync would drop a load. It also switches modes on consecutive clocks, where a design that kept the old phase would open the new mode on a stuff clock.

The reset and first-active clocks are checked so that a design that strobes during reset is caught.

// File: rtl/hbrs_pkg.sv
// Shared types for the half-band rate-change sequencer.
// Assumes: nothing; pure type and constant definitions.
package hbrs_pkg;
    localparam int VAR_A = 0;   // three-mode variant
    localparam int VAR_B = 1;   // adds unity-gain interpolation

    typedef enum logic [1:0] {
        MODE_EQ     = 2'd0,
        MODE_DEC    = 2'd1,
        MODE_IHALF  = 2'd2,
        MODE_IUNITY = 2'd3
    } hb_mode_e;

    typedef enum logic [1:0] {
        GL_UNITY      = 2'd0,
        GL_HALF       = 2'd1,
        GL_HALF_LIM15 = 2'd2
    } gl_code_e;
endpackage

// File: rtl/hbrs_mode_decode.sv
// Decodes the two mode pins into an operating mode.
// Assumes: pins are stable around the sampling edge; VARIANT picks the table.
module hbrs_mode_decode
    import hbrs_pkg::*;
#(
    parameter int VARIANT = VAR_B
) (
    input  logic     dec_i,
    input  logic     int_i,
    output hb_mode_e mode_o
);
    // Pattern 00 is the only entry that differs between variants.
    hb_mode_e both_low_mode;

    generate
        if (VARIANT == VAR_B) begin : g_var_b
            assign both_low_mode = MODE_IUNITY;
        end else begin : g_var_a
            assign both_low_mode = MODE_EQ;
        end
    endgenerate

    // Pin pattern to mode lookup.
    always_comb begin
        unique case ({dec_i, int_i})
            2'b01:   mode_o = MODE_DEC;
            2'b10:   mode_o = MODE_IHALF;
            2'b00:   mode_o = both_low_mode;
            default: mode_o = MODE_EQ;
        endcase
    end
endmodule

// File: rtl/hbrs_phase.sv
// Holds the registered mode, the half-rate phase and the sync history.
// Assumes: mode_d is the decoded pin mode for the current clock.
// accept_o is high on clocks that accept (interpolate) or load (decimate).
module hbrs_phase
    import hbrs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hb_mode_e mode_d,
    input  logic     sync_i,
    output hb_mode_e mode_q,
    output logic     act_q,
    output logic     accept_o
);
    logic stuff_q;    // 1: this clock is the in-between phase
    logic sync_q;     // sync_i one clock ago
    logic align;

    // A falling sync marks an accept clock, except in equal-rate mode.
    assign align    = (mode_q != MODE_EQ) && sync_q && !sync_i;
    assign accept_o = align || !stuff_q;

    // Mode, phase and sync history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_EQ;
            stuff_q <= 1'b0;
            sync_q  <= 1'b0;
            act_q   <= 1'b0;
        end else begin
            act_q  <= 1'b1;
            sync_q <= sync_i;
            mode_q <= mode_d;
            if (mode_d != mode_q) begin
                stuff_q <= 1'b0;
            end else begin
                stuff_q <= accept_o;
            end
        end
    end
endmodule

// File: rtl/hbrs_strobe.sv
// Turns mode and phase into the datapath strobes and the gain/limit code.
// Assumes: act is low during reset and on the first clock after it.
module hbrs_strobe
    import hbrs_pkg::*;
#(
    parameter int VARIANT = VAR_B
) (
    input  hb_mode_e    mode_q,
    input  logic        act,
    input  logic        accept,
    output logic        adv_o,
    output logic        take_o,
    output logic        zero_o,
    output logic        oload_o,
    output logic [1:0]  gain_o
);
    localparam gl_code_e HALF_CODE = (VARIANT == VAR_B) ? GL_HALF_LIM15 : GL_HALF;

    logic interp;

    assign interp = (mode_q == MODE_IHALF) || (mode_q == MODE_IUNITY);

    // Per-clock strobes, gated off while inactive.
    always_comb begin
        adv_o   = act;
        take_o  = act && (interp ? accept : 1'b1);
        zero_o  = act && interp && !accept;
        oload_o = act && ((mode_q == MODE_DEC) ? accept : 1'b1);
    end

    // Gain and limit selection for the output stage.
    always_comb begin
        gain_o = (mode_q == MODE_IHALF) ? HALF_CODE : GL_UNITY;
    end
endmodule

// File: rtl/hb_rate_seq.sv
// Top of the half-band rate-change sequencer.
// Assumes: one master clock; the filter core and output stage use the strobes.
module hb_rate_seq
    import hbrs_pkg::*;
#(
    parameter int VARIANT = VAR_B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_i,
    input  logic       int_i,
    input  logic       sync_i,
    output logic       adv_o,
    output logic       take_o,
    output logic       zero_o,
    output logic       oload_o,
    output logic [1:0] gain_o
);
    hb_mode_e mode_d;
    hb_mode_e mode_q;
    logic     act_q;
    logic     accept;

    hbrs_mode_decode #(.VARIANT(VARIANT)) u_dec (
        .dec_i  (dec_i),
        .int_i  (int_i),
        .mode_o (mode_d)
    );

    hbrs_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_d   (mode_d),
        .sync_i   (sync_i),
        .mode_q   (mode_q),
        .act_q    (act_q),
        .accept_o (accept)
    );

    hbrs_strobe #(.VARIANT(VARIANT)) u_strobe (
        .mode_q  (mode_q),
        .act     (act_q),
        .accept  (accept),
        .adv_o   (adv_o),
        .take_o  (take_o),
        .zero_o  (zero_o),
        .oload_o (oload_o),
        .gain_o  (gain_o)
    );
endmodule

// File: rtl/hbrs_checker.sv
// Port-level properties of the sequencer, bound to every hb_rate_seq.
// Assumes: synchronous active-low reset on rst_n.
module hbrs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_i,
    input logic       adv_o,
    input logic       take_o,
    input logic       zero_o,
    input logic       oload_o,
    input logic [1:0] gain_o
);
    AST_STUFF_THEN_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |=> take_o);                                         // R4
    AST_TAKE_XOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |-> (take_o ^ zero_o));                               // R4
    AST_SKIP_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && !oload_o) |=> oload_o);                           // R5
    AST_SKIP_STILL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && !oload_o) |-> (take_o && !zero_o));               // R5
    AST_SYNC_FALL_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && $past(adv_o) && $past(sync_i) && !sync_i) |-> (take_o && oload_o)); // R6
    AST_GAIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        gain_o != 2'd3);                                            // R8
    AST_ACTIVE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |=> adv_o);                                           // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_o |-> (!take_o && !zero_o && !oload_o));               // R9
endmodule

bind hb_rate_seq hbrs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .adv_o   (adv_o),
    .take_o  (take_o),
    .zero_o  (zero_o),
    .oload_o (oload_o),
    .gain_o  (gain_o)
);

// File: tb/tb_hb_rate_seq.sv
// Compares both variants against a behavioural per-clock model.
module tb_hb_rate_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_i = 1'b1, int_i = 1'b1, sync_i = 1'b0;
    logic a_adv, a_take, a_zero, a_load; logic [1:0] a_gain;
    logic b_adv, b_take, b_zero, b_load; logic [1:0] b_gain;
    int tests = 0, fails = 0;
    bit done = 0;

    // model state, index 0 = variant A, 1 = variant B
    int m_mode [2];   // 0 eq, 1 dec, 2 half interp, 3 unity interp
    int m_stuff [2];
    int m_sprev = 0;
    int m_act = 0;

    always #2 clk = ~clk;

    hb_rate_seq #(.VARIANT(1)) dut (
        .clk(clk), .rst_n(rst_n), .dec_i(dec_i), .int_i(int_i), .sync_i(sync_i),
        .adv_o(b_adv), .take_o(b_take), .zero_o(b_zero), .oload_o(b_load), .gain_o(b_gain));
    hb_rate_seq #(.VARIANT(0)) dut_a (
        .clk(clk), .rst_n(rst_n), .dec_i(dec_i), .int_i(int_i), .sync_i(sync_i),
        .adv_o(a_adv), .take_o(a_take), .zero_o(a_zero), .oload_o(a_load), .gain_o(a_gain));

    function automatic int decode(int v, bit d, bit i);
        if (!d && i) return 1;
        if (d && !i) return 2;
        if (!d && !i) return (v == 1) ? 3 : 0;
        return 0;
    endfunction

    task automatic step(bit r, bit d, bit i, bit s, string tag);
        int acc [2];
        @(negedge clk);
        rst_n = r; dec_i = d; int_i = i; sync_i = s;
        #1;
        for (int v = 0; v < 2; v++) begin
            int m = m_mode[v];
            bit al = (m != 0) && (m_sprev != 0) && !s;
            bit ac = al || (m_stuff[v] == 0);
            bit act = (m_act != 0);
            logic [5:0] expv, actv;
            acc[v] = ac;
            expv[5] = act;
            expv[4] = act && ((m >= 2) ? ac : 1'b1);
            expv[3] = act && (m >= 2) && !ac;
            expv[2] = act && ((m == 1) ? ac : 1'b1);
            expv[1:0] = (m == 2) ? ((v == 1) ? 2'd2 : 2'd1) : 2'd0;
            actv = (v == 1) ? {b_adv, b_take, b_zero, b_load, b_gain}
                            : {a_adv, a_take, a_zero, a_load, a_gain};
            tests++;
            if (actv !== expv) begin
                fails++;
                $display("FAIL %s (variant %0d, mode %0d): got adv/take/zero/load/gain=%b expected %b",
                         tag, v, m, actv, expv);
            end
        end
        @(posedge clk);
        if (!r) begin
            for (int v = 0; v < 2; v++) begin m_mode[v] = 0; m_stuff[v] = 0; end
            m_sprev = 0; m_act = 0;
        end else begin
            for (int v = 0; v < 2; v++) begin
                int nm = decode(v, d, i);
                m_stuff[v] = (nm != m_mode[v]) ? 0 : acc[v];
                m_mode[v] = nm;
            end
            m_sprev = s; m_act = 1;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < 2; v++) begin m_mode[v] = 0; m_stuff[v] = 0; end
        // R9: reset and first active clock
        for (int k = 0; k < 3; k++) step(0, 1, 1, 1, "R9 reset");
        step(1, 1, 1, 0, "R9 first clock");
        step(1, 1, 1, 0, "R9 start");
        // R3: equal-rate, sync toggling has no effect
        for (int k = 0; k < 6; k++) step(1, 1, 1, k[0], "R3 equal-rate");
        // R5: decimation, sync held low
        for (int k = 0; k < 7; k++) step(1, 0, 1, 0, "R5 decimate");
        // R6: realign decimation on an off-phase pulse
        step(1, 0, 1, 1, "R6 decimate sync high");
        step(1, 0, 1, 1, "R6 decimate sync high");
        for (int k = 0; k < 5; k++) step(1, 0, 1, 0, "R6 decimate after sync");
        // R4/R8: half-gain interpolation, sync low
        for (int k = 0; k < 6; k++) step(1, 1, 0, 0, "R4 R8 half interp");
        // R7: sync toggling at half rate
        for (int k = 0; k < 8; k++) step(1, 1, 0, k[0], "R7 toggling sync");
        // R6: off-phase realignment while interpolating
        step(1, 1, 0, 0, "R6 interp");
        step(1, 1, 0, 1, "R6 interp sync high");
        step(1, 1, 0, 0, "R6 interp aligned");
        for (int k = 0; k < 4; k++) step(1, 1, 0, 0, "R6 interp after sync");
        // R1/R2: pattern 00 differs between variants
        for (int k = 0; k < 8; k++) step(1, 0, 0, (k == 3), "R1 R2 pattern 00");
        // R10: mode changes on consecutive clocks
        step(1, 0, 1, 0, "R10 to decimate");
        step(1, 1, 0, 0, "R10 to interp");
        step(1, 0, 1, 0, "R10 to decimate");
        step(1, 1, 1, 1, "R10 to equal");
        step(1, 1, 0, 0, "R10 to interp");
        for (int k = 0; k < 4; k++) step(1, 1, 0, 0, "R10 settle");
        // R9: reset again mid-run
        step(0, 1, 0, 0, "R9 reset mid-run");
        step(1, 1, 0, 0, "R9 first clock");
        for (int k = 0; k < 3; k++) step(1, 1, 0, 0, "R9 start phase");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule